// File: doc/BRIEF.md
# Test-and-Set Lock Engine with Exponential Backoff

This block arbitrates a single shared lock word among several requesters. Each requester raises an acquire request. Its own controller then issues an atomic test-and-set on the lock word. The test-and-set returns the previous value and leaves the word at 1. A requester that reads back 0 owns the lock. Its `acquired` output stays high until it asks to release, and a release stores 0 into the word.

A requester that reads back 1 has failed. It does not retry on the next cycle. It waits a delay that grows geometrically with the number of consecutive failures: K_CYC·2^(C_LOG2·f) cycles after failure f. The exponent stops growing at MAX_EXP, so a waiter is never parked far longer than the lock stays busy. A round-robin arbiter issues at most one test-and-set per cycle. The read and the write of each test-and-set happen in the same cycle, so no other operation can fall between them.

Top module: `tas_backoff_lock`

## Requirements
- R1: While reset is held, `lock_word` is 0, `grant` is all zeros and `acquired` is all zeros.
- R2: At most one bit of `grant` is high in any cycle. A `grant` bit marks the cycle in which that requester's test-and-set executes.
- R3: A requester whose acquire request is sampled while it is idle gets its grant one cycle later if no other requester competes. If the lock word is 0 at its grant, then in the next cycle its `acquired` bit is 1 and `lock_word` is 1.
- R4: A test-and-set executed while `lock_word` is 1 leaves `lock_word` at 1 and does not raise `acquired` for that requester.
- R5: After failure number f (counted from 1 since the last success), the next grant to that requester arrives K_CYC·2^(C_LOG2·f)+1 cycles after the failed grant, provided no other requester competes.
- R6: The exponent f in R5 saturates at MAX_EXP. Every later consecutive failure waits the same capped delay.
- R7: A release request from the holder clears `lock_word` and the holder's `acquired` bit in the next cycle.
- R8: A release request from a requester that does not hold the lock has no effect on `lock_word` or on any `acquired` bit.
- R9: In a cycle in which the holder's release is accepted, no grant is issued.
- R10: The failure count of a requester returns to zero on a successful acquire, so its next first failure waits K_CYC·2^C_LOG2 cycles again.
- R11: Among requesters that are ready together, grants rotate round-robin, starting from the requester after the one granted most recently.
- R12: At most one bit of `acquired` is high at any time.
- R13: An `acquired` bit stays high until that requester's release is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | N_REQ | Per-requester acquire request, sampled while the requester is idle |
| rel_req | input | N_REQ | Per-requester release request, honoured only from the holder |
| grant | output | N_REQ | One-hot marker of the test-and-set executed this cycle |
| acquired | output | N_REQ | Per-requester lock ownership |
| lock_word | output | 1 | Current value of the shared lock word |

## Verification
The bench builds the block with three requesters, K_CYC=3, C_LOG2=1 and MAX_EXP=3. With these values the delays are 6, 12 and then a capped 24 cycles, so the saturation point falls within a few dozen cycles, and the run measures two gaps past it. Three requesters are enough for a round-robin pass to wrap around. They also allow a release to coincide with a ready contender, and they let one requester hold the lock while a second one backs off and a third one tries a release it is not entitled to.

// File: rtl/tas_backoff_lock.sv
module tas_backoff_lock #(
  parameter int N_REQ   = 4,
  parameter int K_CYC   = 2,
  parameter int C_LOG2  = 1,
  parameter int MAX_EXP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] acq_req,
  input  logic [N_REQ-1:0] rel_req,
  output logic [N_REQ-1:0] grant,
  output logic [N_REQ-1:0] acquired,
  output logic             lock_word
);

  localparam int MAX_DLY = K_CYC << (C_LOG2 * MAX_EXP);
  localparam int DLY_W   = $clog2(MAX_DLY + 1);
  localparam int EXP_W   = $clog2(MAX_EXP + 1);
  localparam int IDX_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  typedef enum logic [1:0] {S_IDLE, S_TRY, S_WAIT, S_HELD} st_t;

  logic             lock_q;
  logic [IDX_W-1:0] ptr, gidx;
  logic [N_REQ-1:0] want, held, rel_hit;
  logic             rel_any;

  assign rel_hit   = rel_req & held;
  assign rel_any   = |rel_hit;
  assign acquired  = held;
  assign lock_word = lock_q;

  always_comb begin
    int  j;
    logic found;
    grant = '0;
    gidx  = ptr;
    found = 1'b0;
    for (int o = 0; o < N_REQ; o++) begin
      j = (int'(ptr) + o) % N_REQ;
      if (!found && !rel_any && want[j]) begin
        grant[j] = 1'b1;
        gidx     = IDX_W'(j);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      ptr    <= '0;
    end else begin
      if (rel_any)     lock_q <= 1'b0;
      else if (|grant) lock_q <= 1'b1;
      if (|grant) ptr <= (int'(gidx) == N_REQ - 1) ? '0 : gidx + 1'b1;
    end
  end

  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    st_t              st;
    logic [DLY_W-1:0] cnt;
    logic [EXP_W-1:0] fails, nf;

    assign want[i] = (st == S_TRY);
    assign held[i] = (st == S_HELD);
    assign nf = (fails == EXP_W'(MAX_EXP)) ? fails : fails + 1'b1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st    <= S_IDLE;
        cnt   <= '0;
        fails <= '0;
      end else begin
        case (st)
          S_IDLE: if (acq_req[i]) st <= S_TRY;
          S_TRY: if (grant[i]) begin
            if (!lock_q) begin
              st    <= S_HELD;
              fails <= '0;
            end else begin
              st    <= S_WAIT;
              fails <= nf;
              cnt   <= DLY_W'(K_CYC) << (C_LOG2 * int'(nf));
            end
          end
          S_WAIT: if (cnt <= DLY_W'(1)) st <= S_TRY;
                  else cnt <= cnt - 1'b1;
          default: if (rel_req[i]) st <= S_IDLE;
        endcase
      end
    end

    // R13
    hold_until_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held[i] && !rel_req[i]) |=> held[i]);
    // R6
    dly_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT) |-> (int'(cnt) <= MAX_DLY && cnt != '0));
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R12
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(held));
  // R3
  win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && !lock_q) |=> (lock_q && |held));
  // R4
  lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && lock_q) |=> (lock_q && $stable(held)));
  // R7
  rel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_any |=> !lock_q);

endmodule

// File: tb/tas_backoff_lock_tb.sv
module tas_backoff_lock_tb_top;
  localparam int N = 3;
  localparam int GAP_TAB[5] = '{7, 13, 25, 25, 25};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] acq = '0, rel = '0, grant, acquired;
  logic lock_word;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tas_backoff_lock #(.N_REQ(N), .K_CYC(3), .C_LOG2(1), .MAX_EXP(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .acq_req(acq), .rel_req(rel),
    .grant(grant), .acquired(acquired), .lock_word(lock_word));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_grant(input int idx, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!grant[idx] && n < 200);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, lastg, w;
    repeat (3) @(negedge clk);
    chk(lock_word == 1'b0, "R1 lock_word", lock_word, 0);
    chk(grant == '0, "R1 grant", grant, 0);
    chk(acquired == '0, "R1 acquired", acquired, 0);
    rst_n = 1'b1;

    @(negedge clk); acq[0] = 1'b1;
    wait_grant(0, n); acq[0] = 1'b0;
    chk(n == 1, "R3 grant latency", n, 1);
    @(negedge clk);
    chk(acquired == 3'b001, "R3 acquired", acquired, 1);
    chk(lock_word == 1'b1, "R3 lock_word", lock_word, 1);

    rel[2] = 1'b1; @(negedge clk); rel[2] = 1'b0;
    chk(lock_word == 1'b1, "R8 lock_word", lock_word, 1);
    chk(acquired == 3'b001, "R8 acquired", acquired, 1);

    acq[1] = 1'b1;
    wait_grant(1, n); acq[1] = 1'b0;
    for (int f = 0; f < 5; f++) begin
      @(negedge clk);
      chk(acquired[1] == 1'b0 && lock_word == 1'b1, "R4 failed attempt", acquired, 1);
      wait_grant(1, n);
      chk(n + 1 == GAP_TAB[f], (f < 2) ? "R5 backoff gap" : "R6 capped gap", n + 1, GAP_TAB[f]);
    end

    @(negedge clk); rel[0] = 1'b1;
    @(negedge clk); rel[0] = 1'b0;
    chk(lock_word == 1'b0, "R7 lock_word", lock_word, 0);
    chk(acquired[0] == 1'b0, "R7 acquired", acquired, 0);

    wait_grant(1, n);
    @(negedge clk);
    chk(acquired == 3'b010, "R3 waiter wins", acquired, 2);
    repeat (10) @(negedge clk);
    chk(acquired == 3'b010, "R13 held", acquired, 2);
    rel[1] = 1'b1; @(negedge clk); rel[1] = 1'b0;
    chk(acquired == '0, "R7 release", acquired, 0);

    acq[2] = 1'b1; wait_grant(2, n); acq[2] = 1'b0;
    @(negedge clk);
    chk(acquired == 3'b100, "R3 req2", acquired, 4);
    acq[1] = 1'b1; wait_grant(1, n); acq[1] = 1'b0;
    @(negedge clk);
    chk(acquired[1] == 1'b0, "R4 req1 fails", acquired, 4);
    wait_grant(1, n);
    chk(n + 1 == 7, "R10 count reset", n + 1, 7);
    rel[2] = 1'b1; @(negedge clk); rel[2] = 1'b0;
    wait_grant(1, n);
    @(negedge clk);
    chk(acquired == 3'b010, "R3 req1 again", acquired, 2);
    rel[1] = 1'b1; @(negedge clk); rel[1] = 1'b0;
    lastg = 1;

    acq = 3'b111;
    @(negedge clk); acq = '0;
    for (int k = 0; k < 3; k++) begin
      int e;
      e = (lastg + 1 + k) % N;
      chk(grant == (3'b001 << e), "R11 rotation", grant, 1 << e);
      @(negedge clk);
    end
    w = (lastg + 1) % N;
    chk(acquired == (3'b001 << w), "R12 single owner", acquired, 1 << w);

    wait_grant(0, n);
    rel[2] = 1'b1; #1;
    chk(grant == '0, "R9 no grant on release", grant, 0);
    @(negedge clk); rel[2] = 1'b0;
    chk(lock_word == 1'b0, "R7 lock cleared", lock_word, 0);
    chk(grant == 3'b001, "R11 pointer after 1", grant, 1);
    @(negedge clk);
    chk(acquired == 3'b001, "R3 req0 wins", acquired, 1);
    rel[0] = 1'b1; @(negedge clk); rel[0] = 1'b0;
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule